// File: doc/BRIEF.md
# Synchronous FIFO with Registered Full and Empty Flags

This block is a single-clock first-in first-out queue. Words pushed on the write side go into a small dual-port array at the slot named by a binary write pointer. The array is written on the clock edge. Its read port is combinational, so the word at the read pointer (the oldest word held) is always visible on the output. Each pointer is a plain binary counter. Its count enable is the accepted write or the accepted read.

The two pointers carry no extra wrap bit, so equal pointers alone cannot tell a full queue from an empty one. That question is answered by a three-state fill machine. Its state register is the pair of flag registers.

- **S_EMPTY**: empty=1, full=0.
- **S_PART**: both flags 0.
- **S_FULL**: full=1, empty=0.

Each cycle the machine sees one operation: IDLE, PUSH, POP or BOTH. It also sees whether the pointers will be equal after that operation. It then takes one of these named transitions:

- **FILL_LAST**: a push alone that makes the pointers equal, moving to S_FULL.
- **DRAIN_LAST**: a pop alone that makes the pointers equal, moving to S_EMPTY.
- **LEAVE_EMPTY**: a push that leaves the pointers unequal, moving S_EMPTY to S_PART.
- **LEAVE_FULL**: a pop that leaves the pointers unequal, moving S_FULL to S_PART.
- **HOLD**: any other case, with the state kept.

A separate occupancy counter drives a half-level flag.

A write request while full is refused. A read request while empty is refused. Refused requests move no pointer and change no stored word. When the queue is full and both requests arrive, the read is taken and the write is refused.

Top module: `sync_fifo_rf`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, empty=1, full=0 and half_full=0.
- R2: While the queue holds at least one word, rd_data shows the oldest word held, with no clock delay. Words leave in the order they were accepted.
- R3: A write accepted alone that brings the held count to DEPTH sets full=1 and empty=0 from the next clock edge (FILL_LAST).
- R4: A read accepted alone that brings the held count to 0 sets empty=1 and full=0 from the next clock edge (DRAIN_LAST).
- R5: A write or a read accepted alone that leaves the count strictly between 0 and DEPTH gives full=0 and empty=0 after the edge (LEAVE_EMPTY, LEAVE_FULL, or HOLD in S_PART).
- R6: A cycle with neither wr_en nor rd_en leaves full, empty, half_full and rd_data unchanged.
- R7: When a write and a read are both accepted in one cycle, the flags and the count are unchanged and order is kept.
- R8: wr_en while full=1 is ignored: no word is stored, the held words are unchanged, and full stays 1 unless a read is accepted in the same cycle.
- R9: rd_en while empty=1 is ignored: empty stays 1 unless a write is accepted in the same cycle, and no word is lost or repeated later.
- R10: half_full is 1 exactly when the held count is at least DEPTH/2.
- R11: full and empty are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to the empty state |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store on an accepted write |
| rd_en | input | 1 | Read request; an accepted read drops the word on rd_data |
| rd_data | output | WIDTH | Oldest word held (combinational read of the array) |
| full | output | 1 | Registered flag: DEPTH words held |
| empty | output | 1 | Registered flag: no word held |
| half_full | output | 1 | At least DEPTH/2 words held |

## Verification
The assertions assume a few things about the inputs:

- the run begins with rst_n held low across at least one rising edge;
- wr_en and rd_en are known, never X, at every rising edge;
- the checker's own count of accepted requests is therefore a fair reference.

The bench holds reset low for two edges before any request. It changes inputs only on the falling edge, to defined 0/1 values. Its requests, whether from sweeps or random draws, are legal in every state, including refused writes while full and refused reads while empty. So nothing it drives leaves the assumed input space.

// File: rtl/fifo_rf_pkg.sv
package fifo_rf_pkg;

    // Flag registers double as the fill state: {full, empty}
    typedef enum logic [1:0] {
        S_PART  = 2'b00,
        S_EMPTY = 2'b01,
        S_FULL  = 2'b10
    } fill_state_e;

    // Operation actually performed this cycle (after refusal gating)
    typedef enum logic [1:0] {
        OP_IDLE = 2'b00,
        OP_POP  = 2'b01,
        OP_PUSH = 2'b10,
        OP_BOTH = 2'b11
    } fifo_op_e;

    function automatic fifo_op_e op_of(input logic push, input logic pop);
        return fifo_op_e'({push, pop});
    endfunction

endpackage

// File: rtl/fifo_rf_ptr.sv
module fifo_rf_ptr #(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic [AW-1:0] ptr_next
);
    // Binary counter whose count enable is the accepted request
    always_comb begin
        ptr_next = step ? ptr + AW'(1) : ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else begin
            ptr <= ptr_next;
        end
    end
endmodule

// File: rtl/fifo_rf_mem.sv
module fifo_rf_mem #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] cells [DEPTH];

    // Synchronous write port
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Asynchronous read port
    assign rdata = cells[raddr];
endmodule

// File: rtl/fifo_rf_flags.sv
module fifo_rf_flags
    import fifo_rf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    input  logic ptr_eq,
    output logic full,
    output logic empty
);
    fill_state_e state, state_nxt;
    fifo_op_e    op;

    assign op = op_of(push, pop);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: FILL_LAST, DRAIN_LAST, LEAVE_EMPTY, LEAVE_FULL, HOLD
    always_comb begin
        state_nxt = state;
        unique case (state)
            S_EMPTY: begin
                if (op == OP_PUSH) begin
                    state_nxt = ptr_eq ? S_FULL : S_PART;
                end
            end
            S_PART: begin
                unique case (op)
                    OP_PUSH: state_nxt = ptr_eq ? S_FULL  : S_PART;
                    OP_POP:  state_nxt = ptr_eq ? S_EMPTY : S_PART;
                    OP_IDLE,
                    OP_BOTH: state_nxt = S_PART;
                    default: state_nxt = S_PART;
                endcase
            end
            S_FULL: begin
                if (op == OP_POP) begin
                    state_nxt = ptr_eq ? S_EMPTY : S_PART;
                end
            end
            default: state_nxt = S_EMPTY;
        endcase
    end

    // Output decode
    always_comb begin
        full  = (state == S_FULL);
        empty = (state == S_EMPTY);
    end
endmodule

// File: rtl/fifo_rf_level.sv
module fifo_rf_level #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  logic pop,
    output logic half
);
    localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2);

    logic [CW-1:0] level;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level <= '0;
        end else if (push && !pop) begin
            level <= level + CW'(1);
        end else if (pop && !push) begin
            level <= level - CW'(1);
        end
    end

    assign half = (level >= HALF_MARK);
endmodule

// File: rtl/sync_fifo_rf.sv
module sync_fifo_rf #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty,
    output logic             half_full
);
    localparam int AW = $clog2(DEPTH);

    logic          push, pop, ptr_eq;
    logic [AW-1:0] wptr, wptr_nxt, rptr, rptr_nxt;

    // Refusal gating: no write while full, no read while empty
    assign push = wr_en && !full;
    assign pop  = rd_en && !empty;

    fifo_rf_ptr #(.AW(AW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .step(push),
        .ptr(wptr), .ptr_next(wptr_nxt)
    );

    fifo_rf_ptr #(.AW(AW)) u_rptr (
        .clk(clk), .rst_n(rst_n), .step(pop),
        .ptr(rptr), .ptr_next(rptr_nxt)
    );

    // Single comparator on the post-operation pointers
    assign ptr_eq = (wptr_nxt == rptr_nxt);

    fifo_rf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data),
        .raddr(rptr), .rdata(rd_data)
    );

    fifo_rf_flags u_flags (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .ptr_eq(ptr_eq), .full(full), .empty(empty)
    );

    fifo_rf_level #(.DEPTH(DEPTH)) u_level (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .half(half_full)
    );
endmodule

// File: rtl/sync_fifo_rf_chk.sv
module sync_fifo_rf_chk #(
    parameter int DEPTH = 8
) (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic rd_en,
    input logic full,
    input logic empty,
    input logic half_full
);
    localparam int CW = $clog2(DEPTH) + 1;

    logic [CW-1:0] cnt;
    logic          acc_w, acc_r;

    assign acc_w = wr_en && !full;
    assign acc_r = rd_en && !empty;

    // Reference count built from port handshakes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (acc_w && !acc_r) begin
            cnt <= cnt + CW'(1);
        end else if (acc_r && !acc_w) begin
            cnt <= cnt - CW'(1);
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && !half_full));

    // R3
    fill_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_w && !rd_en && cnt == CW'(DEPTH - 1)) |=> (full && !empty));

    // R4
    drain_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_r && !wr_en && cnt == CW'(1)) |=> (empty && !full));

    // R5
    mid_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_w && !rd_en && cnt != CW'(DEPTH - 1)) ||
         (acc_r && !wr_en && cnt != CW'(1))) |=> (!full && !empty));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> ($stable(full) && $stable(empty) && $stable(half_full)));

    // R7
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_w && acc_r) |=> ($stable(full) && $stable(empty) && $stable(half_full)));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> full);

    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en && !wr_en) |=> empty);

    // R10
    half_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_full == (cnt >= CW'(DEPTH / 2)));

    // R11
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));
endmodule

bind sync_fifo_rf sync_fifo_rf_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .full(full), .empty(empty), .half_full(half_full)
);

// File: tb/sync_fifo_rf_test.sv
module sync_fifo_rf_test;
    localparam int W = 8;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         full, empty, half_full;

    always #10 clk = ~clk;  // 50 MHz

    sync_fifo_rf #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .full(full), .empty(empty),
        .half_full(half_full)
    );

    logic [W-1:0] q[$];
    logic [W-1:0] seq = 8'h11;
    int tests = 0;
    int fails = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 empty in reset", 32'(empty), 32'd1);
        chk("R1 full in reset", 32'(full), 32'd0);
        rst_n = 1'b1;
        q.delete();
        @(negedge clk);
        chk("R1 empty after reset", 32'(empty), 32'd1);
        chk("R1 full after reset", 32'(full), 32'd0);
        chk("R1 half after reset", 32'(half_full), 32'd0);
    endtask

    task automatic step(input logic we, input logic re);
        bit acc_w, acc_r;
        int nsz;
        string tag;
        logic [W-1:0] prev_data;
        @(negedge clk);
        wr_en = we; rd_en = re; wr_data = seq;
        #1;
        acc_w = we && (q.size() < D);
        acc_r = re && (q.size() > 0);
        nsz = q.size() + int'(acc_w) - int'(acc_r);
        prev_data = rd_data;
        if (!we && !re)          tag = "R6";
        else if (acc_w && acc_r) tag = "R7";
        else if (we && !acc_w)   tag = "R8";
        else if (re && !acc_r)   tag = "R9";
        else if (acc_w)          tag = (nsz == D) ? "R3" : "R5";
        else                     tag = (nsz == 0) ? "R4" : "R5";
        if (acc_r) chk("R2 head before pop", 32'(rd_data), 32'(q[0]));
        @(posedge clk);
        #1;
        if (acc_r) void'(q.pop_front());
        if (acc_w) q.push_back(seq);
        if (we) seq = seq + 8'h27;
        chk({tag, " empty"}, 32'(empty), 32'(q.size() == 0));
        chk({tag, " full"}, 32'(full), 32'(q.size() == D));
        chk("R10 half", 32'(half_full), 32'(q.size() >= D / 2));
        chk("R11 exclusive", 32'(full && empty), 32'd0);
        if (q.size() > 0) chk({tag, " head"}, 32'(rd_data), 32'(q[0]));
        if (!we && !re && q.size() > 0) chk("R6 data held", 32'(rd_data), 32'(prev_data));
    endtask

    initial begin
        // Near-exhaustive: every request pair at every fill level
        for (int occ = 0; occ <= D; occ++) begin
            for (int op = 0; op < 4; op++) begin
                do_reset();
                for (int k = 0; k < occ; k++) step(1'b1, 1'b0);
                step(op[1], op[0]);
                step(1'b1, 1'b1);
                step(1'b0, 1'b0);
                while (q.size() > 0) step(1'b0, 1'b1);
                step(1'b0, 1'b1);   // R9 read while empty
            end
        end
        // Overfill then drain: refused writes leave no trace (R8)
        do_reset();
        for (int k = 0; k < D + 3; k++) step(1'b1, 1'b0);
        while (q.size() > 0) step(1'b0, 1'b1);
        // Random traffic
        for (int k = 0; k < 3000; k++) begin
            int r = int'($urandom_range(0, 3));
            step(r[1], r[0]);
        end
        while (q.size() > 0) step(1'b0, 1'b1);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule